// File: doc/BRIEF.md
# Word-Serial Montgomery Multiplier with Relaxed Final Correction

This block takes two operands `a` and `b`, an odd modulus `m` and the digit constant `k0`, and returns a word `X` of `n` bits such that `X·2^n ≡ a·b (mod m)`. The operands and the modulus are each `n` bits wide. The operands may hold any value below `2^n`, including values at or above `m`. The result always fits in `n` bits, but it is not guaranteed to be below `m`. That makes the block suitable for long chains of modular products, such as an exponentiation loop, where each output feeds straight back as an input. A single full reduction can then run once at the end of the chain, outside this block.

The work is spread over digits of `s` bits, with `k = n/s`.
- **Multiply phase (`k` cycles):** the full `2n`-bit product is built by a shift-and-accumulate of one `s`-bit digit of `a` against all of `b`, taking the most significant digit first.
- **Reduction phase (`k` cycles):** each cycle takes the low digit of the accumulator, multiplies it by `k0` modulo `2^s`, adds that multiple of `m` and drops the now-zero low digit.
- **Correction (1 cycle):** a single subtraction always runs. It removes `m` when the sum has reached `2^n` and removes zero otherwise, so the timing never depends on the data.

Both ends of the block are valid/ready streams.
- **Input side:** an operand set is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block holds no work, so one product is in flight at a time. `in_valid` is not sampled while the block is busy.
- **Output side:** the result is presented with `out_valid` and held, unchanged, until the consumer raises `out_ready`. A consumer that holds `out_ready` low stalls the block. No new operands are accepted until the result has been taken.

Top module: `montmul_wserial`

## Requirements
- R1: After reset is released and before any operand set is accepted, `out_valid` is low and `in_ready` is high.
- R2: An operand set is captured only on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low from that edge until the result has been taken, and any `in_valid` or operand change during that time has no effect on the result.
- R3: For odd `m` and any `a`, `b` below `2^n`, the result satisfies `(out_x·2^n) mod m = (a·b) mod m`.
- R4: Let `q` be the unique value below `2^n` with `a·b + q·m ≡ 0 (mod 2^n)`, and let `T = (a·b + q·m)/2^n`. Then `out_x` equals `T − m` when `T ≥ 2^n`, and equals `T` otherwise.
- R5: When `in_k0` equals `−m^(−1) mod 2^s`, each reduction cycle leaves the low `s` bits of the sum at zero before the shift.
- R6: The value entering the correction is below `2^n + m`, and the corrected value fits in `n` bits.
- R7: `out_valid` rises on the `(2k+1)`-th rising edge after the accepting edge, whatever the operand values. The accepting cycle and the valid cycle together span `2k+2` cycles.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_x` stays unchanged. `out_valid` falls only after an edge where `out_ready` was high.
- R9: The boundary sets are computed as R3 and R4 require. These are: `a = b = 2^n − 1` with `m = 2^n − 1`, `m = 1` and `m = 3`; and `a = 0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block is idle and will take an operand set |
| in_a | input | N_W | Multiplicand, any value below 2^n |
| in_b | input | N_W | Multiplier, any value below 2^n |
| in_mod | input | N_W | Odd modulus |
| in_k0 | input | D_W | Digit constant −m^(−1) mod 2^s |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_x | output | N_W | Result, congruent to a·b·2^(−n) mod m |

## Verification
The assertions assume that the modulus is odd and that `in_k0` is the true negated inverse of `m` modulo `2^s`. Without that, the per-digit cancellation and the bound before correction have no reason to hold. The bench never offers a modulus without forcing its low bit to one. It derives `k0` for every operand set with its own Newton inversion before driving the set, so every stimulus meets those conditions. The operands themselves range freely over `n` bits, including all-ones. The consumer side is driven both always-ready and with random stalls, to exercise the hold rules.

// File: rtl/mws_pkg.sv
`timescale 1ns/1ps
package mws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_RED,
    ST_FIN,
    ST_OUT
  } mws_state_e;
endpackage

// File: rtl/mws_mac.sv
`timescale 1ns/1ps
// One multiply-accumulate step: acc * 2^s + digit * b.
module mws_mac #(
  parameter int N_W = 64,
  parameter int D_W = 16
) (
  input  logic [2*N_W:0]   acc_i,
  input  logic [D_W-1:0]   dig_i,
  input  logic [N_W-1:0]   b_i,
  output logic [2*N_W:0]   acc_o
);
  localparam int AW = 2 * N_W + 1;
  localparam int PW = N_W + D_W;

  logic [PW-1:0] prod;

  assign prod  = {{N_W{1'b0}}, dig_i} * {{D_W{1'b0}}, b_i};
  assign acc_o = (acc_i << D_W) + AW'(prod);
endmodule

// File: rtl/mws_redc.sv
`timescale 1ns/1ps
// One reduction step: add y*m so the low digit cancels, then drop that digit.
module mws_redc #(
  parameter int N_W = 64,
  parameter int D_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [2*N_W:0]   acc_i,
  input  logic [N_W-1:0]   m_i,
  input  logic [D_W-1:0]   k0_i,
  output logic [2*N_W:0]   acc_o
);
  localparam int AW = 2 * N_W + 1;
  localparam int PW = N_W + D_W;

  logic [D_W-1:0] y;
  logic [PW-1:0]  ym;
  logic [AW-1:0]  sum;

  assign y     = D_W'(acc_i[D_W-1:0] * k0_i);
  assign ym    = {{N_W{1'b0}}, y} * {{D_W{1'b0}}, m_i};
  assign sum   = acc_i + AW'(ym);
  assign acc_o = sum >> D_W;

  AST_DIGIT_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (sum[D_W-1:0] == '0)); // R5
endmodule

// File: rtl/mws_fix.sv
`timescale 1ns/1ps
// Constant-time correction: always subtracts, either m or zero.
module mws_fix #(
  parameter int N_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [N_W:0]     t_i,
  input  logic [N_W-1:0]   m_i,
  output logic [N_W-1:0]   x_o
);
  logic [N_W-1:0] sub;
  logic [N_W:0]   diff;

  assign sub  = t_i[N_W] ? m_i : '0;
  assign diff = t_i - {1'b0, sub};
  assign x_o  = diff[N_W-1:0];

  AST_FIX_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (diff[N_W] == 1'b0)); // R6
endmodule

// File: rtl/montmul_wserial.sv
`timescale 1ns/1ps
module montmul_wserial #(
  parameter int N_W = 64,
  parameter int D_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [N_W-1:0]   in_a,
  input  logic [N_W-1:0]   in_b,
  input  logic [N_W-1:0]   in_mod,
  input  logic [D_W-1:0]   in_k0,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [N_W-1:0]   out_x
);
  import mws_pkg::*;

  localparam int K   = N_W / D_W;
  localparam int CW  = $clog2(K + 1);
  localparam int LW  = $clog2(2 * K + 3);
  localparam int AW  = 2 * N_W + 1;

  mws_state_e     state;
  logic [N_W-1:0] a_r, b_r, m_r, x_r;
  logic [D_W-1:0] k0_r;
  logic [AW-1:0]  t_r;
  logic [CW-1:0]  cnt;
  logic [LW-1:0]  lat;
  logic [AW-1:0]  mac_out, red_out;
  logic [N_W-1:0] fix_out;
  logic           last_dig;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_OUT);
  assign out_x     = x_r;
  assign last_dig  = (cnt == CW'(K - 1));

  mws_mac #(.N_W(N_W), .D_W(D_W)) u_mac (
    .acc_i (t_r),
    .dig_i (a_r[N_W-1 -: D_W]),
    .b_i   (b_r),
    .acc_o (mac_out)
  );

  mws_redc #(.N_W(N_W), .D_W(D_W)) u_redc (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (state == ST_RED),
    .acc_i (t_r),
    .m_i   (m_r),
    .k0_i  (k0_r),
    .acc_o (red_out)
  );

  mws_fix #(.N_W(N_W)) u_fix (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (state == ST_FIN),
    .t_i   (t_r[N_W:0]),
    .m_i   (m_r),
    .x_o   (fix_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      a_r   <= '0;
      b_r   <= '0;
      m_r   <= '0;
      k0_r  <= '0;
      t_r   <= '0;
      x_r   <= '0;
      cnt   <= '0;
      lat   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          a_r   <= in_a;
          b_r   <= in_b;
          m_r   <= in_mod;
          k0_r  <= in_k0;
          t_r   <= '0;
          cnt   <= '0;
          lat   <= '0;
          state <= ST_MUL;
        end
        ST_MUL: begin
          t_r <= mac_out;
          a_r <= a_r << D_W;
          lat <= lat + 1'b1;
          cnt <= last_dig ? '0 : cnt + 1'b1;
          if (last_dig) state <= ST_RED;
        end
        ST_RED: begin
          t_r <= red_out;
          lat <= lat + 1'b1;
          cnt <= last_dig ? '0 : cnt + 1'b1;
          if (last_dig) state <= ST_FIN;
        end
        ST_FIN: begin
          x_r   <= fix_out;
          lat   <= lat + 1'b1;
          state <= ST_OUT;
        end
        ST_OUT: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_PRE_FIX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIN) |-> ((t_r[AW-1:N_W+1] == '0) &&
      ({1'b0, t_r[N_W:0]} < ({2'b01, {N_W{1'b0}}} + {2'b00, m_r})))); // R6
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat == LW'(2 * K + 1))); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x))); // R8
  AST_OUT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready)); // R8
  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !out_valid) |=> $stable(m_r) && $stable(b_r)); // R2
endmodule

// File: tb/montmul_wserial_tb.sv
`timescale 1ns/1ps
module montmul_wserial_tb;
  localparam int N = 64;
  localparam int S = 16;
  localparam int K = N / S;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N-1:0] in_a = '0, in_b = '0, in_mod = '0;
  logic [S-1:0] in_k0 = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [N-1:0] out_x;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;

  logic [N-1:0] qa[$], qb[$], qm[$];
  int           qacc[$];
  string        qtag[$];

  montmul_wserial #(.N_W(N), .D_W(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_mod(in_mod), .in_k0(in_k0),
    .out_valid(out_valid), .out_ready(out_ready), .out_x(out_x)
  );

  always #2.5 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial forever begin
    @(posedge clk);
    #1;
    out_ready = stall_mode ? 1'($urandom % 2) : 1'b1;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [255:0] inv_pow2(input logic [255:0] m, input int bits);
    logic [255:0] mask, inv;
    mask = (256'd1 << bits) - 1;
    inv  = 256'd1;
    for (int i = 0; i < 8; i++)
      inv = (inv * ((256'd2 - ((m * inv) & mask)) & mask)) & mask;
    return inv;
  endfunction

  task automatic send(input logic [N-1:0] a, input logic [N-1:0] b,
                      input logic [N-1:0] m, input string tag, input bit junk);
    logic [255:0] mi;
    logic [N-1:0] mo;
    mo = m | 1;
    mi = inv_pow2({192'd0, mo}, S);
    @(negedge clk);
    in_valid = 1'b1;
    in_a = a; in_b = b; in_mod = mo;
    in_k0 = S'((256'd1 << S) - mi[S-1:0]);
    while (!in_ready) @(negedge clk);
    qa.push_back(a); qb.push_back(b); qm.push_back(mo);
    qacc.push_back(cyc + 1); qtag.push_back(tag);
    @(negedge clk);
    check(in_ready == 1'b0, "R2", "in_ready after accept", in_ready, 0);
    if (junk) begin
      in_a = ~a; in_b = ~b; in_mod = 64'h5; in_k0 = '1;
      repeat (3) @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // Scoreboard monitor
  initial begin
    bit prev_ov = 1'b0, prev_rdy = 1'b0;
    logic [N-1:0] held = '0;
    forever begin
      @(negedge clk);
      if (out_valid && !prev_ov && qa.size() > 0) begin
        logic [255:0] ab, mi, q, t, ex, mw, mask;
        logic [N-1:0] a, b, m;
        int acc;
        string tg;
        a = qa.pop_front(); b = qb.pop_front(); m = qm.pop_front();
        acc = qacc.pop_front(); tg = qtag.pop_front();
        mask = (256'd1 << N) - 1;
        mw = {192'd0, m};
        ab = {192'd0, a} * {192'd0, b};
        mi = inv_pow2(mw, N);
        q  = (((256'd1 << N) - (ab & mask)) * mi) & mask;
        t  = (ab + q * mw) >> N;
        ex = (t >= (256'd1 << N)) ? t - mw : t;
        // R4 R5 R6: exact value of the relaxed correction
        check(out_x == ex[N-1:0], {tg, " R4 R5 R6"}, "exact result", out_x, ex);
        check((({192'd0, out_x} << N) % mw) == (ab % mw), {tg, " R3"},
              "congruence", ({192'd0, out_x} << N) % mw, ab % mw);
        check(cyc - acc == 2 * K + 1, "R7", "latency edges", cyc - acc, 2 * K + 1);
        held = out_x;
      end else if (out_valid && prev_ov && !prev_rdy) begin
        check(out_x == held, "R8", "held result", out_x, held);
        check(in_ready == 1'b0, "R8", "in_ready while result pending", in_ready, 0);
      end
      prev_ov  = out_valid;
      prev_rdy = out_ready;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [N-1:0] ones;
    ones = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    send(ones, ones, ones, "R9", 1'b0);
    send(ones, ones, 64'd1, "R9", 1'b0);
    send(ones, ones, 64'd3, "R9", 1'b0);
    send('0, ones, 64'hF123_4567_89AB_CDEF, "R9", 1'b0);
    send(64'h8000_0000_0000_006E, 64'h4000_0000_0000_0035,
         64'h8000_0000_0000_006F, "R3", 1'b0);
    send({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
         "R2", 1'b1);
    for (int i = 0; i < 40; i++) begin
      stall_mode = (i >= 20);
      send({$urandom, $urandom}, {$urandom, $urandom},
           {1'b1, 31'($urandom), $urandom}, "R3", 1'b0);
    end
    stall_mode = 1'b0;
    while (qa.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule